// File: doc/BRIEF.md
# Indexed-Memory Pseudo-Random Word Generator

This block produces a stream of 32-bit pseudo-random words from a 64-word state memory, two accumulators and a running index. Each result is built in two fixed stages of five clock ticks. The first stage fetches the current memory word and folds a shifted copy of accumulator A into A. It then adds the word that sits half the memory away. The second stage forms a new memory word from an indirect fetch plus both accumulators and writes it back at the current index. A second indirect fetch, keyed by the word just written, plus the old memory word, becomes the new B and the output word.

Every sum goes through one shared adder. The adder adds the low half in one tick and the high half in the next. The state memory is split into two banks of 32 words. It is read combinationally and written on the falling clock edge, while every other register loads on the rising edge at its own tick of the stage. A start request that arrives at any point is latched and acted on at the next stage boundary. Holding the request high gives one word every ten cycles. A seed-load strobe puts the whole state back to the all-ones seed.

Top module: `idxmix_prng`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `resValid` is 0 and `resWord` is 0. The state after reset is: every memory word 32'hFFFFFFFF, A = B = 32'hFFFFFFFF, index I = 0.
- R2: Each result first updates A to (A ^ s(A)) + m[I XOR 32]. Here s is selected by I[1:0]: 0 gives A<<13, 1 gives A>>6, 2 gives A<<2, 3 gives A>>16. Shifts are logical and sums are modulo 2^32.
- R3: With x = m[I] read before any write, y = m[x[7:2]] + A + B, using the new A and the old B. y is stored to m[I] before the next fetch. The write lands on the falling edge one tick after the sum completes.
- R4: The new B is m[y[13:8]] + x, with that fetch seeing the freshly written m[I]. B appears on `resWord`, and I then advances by one modulo 64, so the index wraps after 64 results.
- R5: `resValid` is high for exactly one cycle per result. `resWord` changes only on that cycle and holds its value otherwise.
- R6: With `startReq` held high, consecutive `resValid` pulses are exactly 10 cycles apart.
- R7: A one-cycle `startReq` is never lost, whether it comes while idle or mid-stage. The `resValid` for it rises 10 to 14 cycles after the first rising edge that samples the request. A request made while a result is in progress starts the next result right after, giving a 10-cycle gap.
- R8: A one-cycle `seedLoad` abandons any work and clears `resWord` and `resValid`. It restores the R1 state, so the next results repeat the sequence seen after reset.
- R9: With no request, no `resValid` pulse occurs and the generator state is left untouched. The next result continues the sequence where it stopped.
- R10: Each 32-bit sum occupies the shared adder for two consecutive ticks, low half then high half. A second sum never starts while one is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers on the rising edge, state memory on the falling edge |
| rst | input | 1 | Synchronous active-high reset to the seed state |
| seedLoad | input | 1 | Synchronous strobe that reloads the all-ones seed state |
| startReq | input | 1 | Request for a result; latched until the next stage boundary |
| resWord | output | 32 | Most recent result word |
| resValid | output | 1 | One-cycle pulse when a new result is on `resWord` |

## Verification
A wrong accumulator, index or memory word shows up at the ports as a miscompare against an independent software model. It appears on the very next result, because every output depends on A, B, I and three memory reads. Errors in rarely touched memory words surface later, when an indirect fetch first lands on them. The long stream that wraps the index past 64 makes sure every word is both written and read back. Schedule faults, such as a register loading a tick early or a missing carry between adder halves, corrupt the first word after reset. Cadence and latency faults are measured directly as cycle gaps between `resValid` pulses.

// File: rtl/idxmix_pkg.sv
package idxmix_pkg;

  localparam int unsigned STAGE_TICKS = 5;
  localparam int unsigned XIDX_LSB = 2;
  localparam int unsigned YIDX_LSB = 8;
  localparam int unsigned SH_L0 = 13;
  localparam int unsigned SH_R1 = 6;
  localparam int unsigned SH_L2 = 2;
  localparam int unsigned SH_R3 = 16;

  // Operand / read-address selection for the current tick
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CUR,
    SEL_MIX,
    SEL_AB,
    SEL_XIND,
    SEL_YIND
  } sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_MIX,
    PH_SCATTER
  } phase_e;

  typedef struct packed {
    logic ldX;
    logic ldM;
    sel_e sel;
    logic addLo;
    logic addHi;
    logic ldA;
    logic memWr;
    logic emit;
  } strobe_t;

endpackage

// File: rtl/idxmix_ctrl.sv
module idxmix_ctrl
  import idxmix_pkg::*;
#(
  parameter int unsigned TICKS = STAGE_TICKS
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    seedLoad,
  input  logic    startReq,
  output strobe_t strb
);

  localparam int unsigned TW = $clog2(TICKS);

  logic [TW-1:0] tick;
  phase_e        phase;
  logic          pending;
  logic          want;
  logic          lastTick;
  logic          launch;

  assign lastTick = (tick == TW'(TICKS - 1));
  assign want     = pending | startReq;
  assign launch   = lastTick && (phase != PH_MIX) && want;

  always_ff @(posedge clk) begin
    if (rst || seedLoad) begin
      tick    <= '0;
      phase   <= PH_IDLE;
      pending <= 1'b0;
    end else begin
      tick    <= lastTick ? '0 : tick + 1'b1;
      pending <= launch ? 1'b0 : want;
      if (lastTick) begin
        unique case (phase)
          PH_MIX:  phase <= PH_SCATTER;
          default: phase <= launch ? PH_MIX : PH_IDLE;
        endcase
      end
    end
  end

  // Fixed five-tick schedule; the adder is busy on ticks 1-4 of the first
  // stage and 0-3 of the second, never with two sums in flight.
  always_comb begin
    strb = '0;
    unique case (phase)
      PH_MIX: begin
        case (tick)
          TW'(0): begin strb.ldX = 1'b1; strb.ldM = 1'b1; strb.sel = SEL_CUR; end
          TW'(1): begin strb.sel = SEL_MIX; strb.addLo = 1'b1; end
          TW'(2): begin strb.sel = SEL_MIX; strb.addHi = 1'b1; end
          TW'(3): begin strb.sel = SEL_AB; strb.addLo = 1'b1; strb.ldA = 1'b1; end
          TW'(4): begin strb.sel = SEL_AB; strb.addHi = 1'b1; end
          default: ;
        endcase
      end
      PH_SCATTER: begin
        case (tick)
          TW'(0): begin strb.sel = SEL_XIND; strb.addLo = 1'b1; end
          TW'(1): begin strb.sel = SEL_XIND; strb.addHi = 1'b1; end
          TW'(2): begin strb.sel = SEL_YIND; strb.addLo = 1'b1; strb.memWr = 1'b1; end
          TW'(3): begin strb.sel = SEL_YIND; strb.addHi = 1'b1; end
          TW'(4): begin strb.emit = 1'b1; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/idxmix_adder.sv
module idxmix_adder #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              addLo,
  input  logic              addHi,
  output logic [WORD_W-1:0] sum
);

  localparam int unsigned LO_W = WORD_W / 2;
  localparam int unsigned HI_W = WORD_W - LO_W;

  logic [LO_W-1:0] loPart;
  logic            carry;
  logic [LO_W:0]   loSum;
  logic [HI_W-1:0] hiSum;

  assign loSum = {1'b0, opA[LO_W-1:0]} + {1'b0, opB[LO_W-1:0]};
  assign hiSum = opA[WORD_W-1:LO_W] + opB[WORD_W-1:LO_W] + HI_W'(carry);

  // Low half on the first tick, high half plus carry on the second;
  // the visible sum changes only when both halves are done.
  always_ff @(posedge clk) begin
    if (rst) begin
      loPart <= '0;
      carry  <= 1'b0;
      sum    <= '0;
    end else begin
      if (addLo) {carry, loPart} <= loSum;
      if (addHi) sum <= {hiSum, loPart};
    end
  end

endmodule

// File: rtl/idxmix_mem.sv
module idxmix_mem #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              init,
  input  logic [IDX_W-1:0]  rdAddr,
  output logic [WORD_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [WORD_W-1:0] wrData
);

  localparam int unsigned BANK_W     = IDX_W - 1;
  localparam int unsigned BANK_WORDS = 1 << BANK_W;
  localparam int unsigned NBANKS     = 2;

  logic [WORD_W-1:0] bankRd [NBANKS];

  for (genvar bk = 0; bk < NBANKS; bk++) begin : g_bank
    logic [WORD_W-1:0] cells [BANK_WORDS];

    // Written on the falling edge, half a tick after the strobes settle
    always_ff @(negedge clk) begin
      if (init) begin
        for (int w = 0; w < BANK_WORDS; w++) cells[w] <= '1;
      end else if (wrEn && (wrAddr[IDX_W-1] == 1'(bk))) begin
        cells[wrAddr[BANK_W-1:0]] <= wrData;
      end
    end

    assign bankRd[bk] = cells[rdAddr[BANK_W-1:0]];
  end

  assign rdData = bankRd[rdAddr[IDX_W-1]];

endmodule

// File: rtl/idxmix_dpath.sv
module idxmix_dpath
  import idxmix_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seedLoad,
  input  strobe_t           strb,
  output logic [WORD_W-1:0] resWord,
  output logic              resValid
);

  localparam logic [IDX_W-1:0] HALF_OFS = {1'b1, {(IDX_W-1){1'b0}}};

  logic              init;
  logic [WORD_W-1:0] accA, accB, curX, mixM;
  logic [WORD_W-1:0] sumOut, rdData, opA, opB, shifted;
  logic [IDX_W-1:0]  idxI, rdAddr;

  assign init = rst | seedLoad;

  always_comb begin
    unique case (strb.sel)
      SEL_MIX:  rdAddr = idxI ^ HALF_OFS;
      SEL_XIND: rdAddr = curX[XIDX_LSB +: IDX_W];
      SEL_YIND: rdAddr = sumOut[YIDX_LSB +: IDX_W];
      default:  rdAddr = idxI;
    endcase
  end

  always_comb begin
    unique case (strb.sel)
      SEL_MIX:  begin opA = mixM;   opB = rdData; end
      SEL_AB:   begin opA = sumOut; opB = accB;   end
      SEL_XIND: begin opA = rdData; opB = sumOut; end
      SEL_YIND: begin opA = rdData; opB = curX;   end
      default:  begin opA = '0;     opB = '0;     end
    endcase
  end

  always_comb begin
    unique case (idxI[1:0])
      2'd0:    shifted = accA << SH_L0;
      2'd1:    shifted = accA >> SH_R1;
      2'd2:    shifted = accA << SH_L2;
      default: shifted = accA >> SH_R3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (init) begin
      accA     <= '1;
      accB     <= '1;
      curX     <= '0;
      mixM     <= '0;
      idxI     <= '0;
      resWord  <= '0;
      resValid <= 1'b0;
    end else begin
      resValid <= strb.emit;
      if (strb.ldX) curX <= rdData;
      if (strb.ldM) mixM <= accA ^ shifted;
      if (strb.ldA) accA <= sumOut;
      if (strb.emit) begin
        accB    <= sumOut;
        resWord <= sumOut;
        idxI    <= idxI + 1'b1;
      end
    end
  end

  idxmix_adder #(.WORD_W(WORD_W)) u_add (
    .clk   (clk),
    .rst   (init),
    .opA   (opA),
    .opB   (opB),
    .addLo (strb.addLo),
    .addHi (strb.addHi),
    .sum   (sumOut)
  );

  idxmix_mem #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_mem (
    .clk    (clk),
    .init   (init),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .wrEn   (strb.memWr),
    .wrAddr (idxI),
    .wrData (sumOut)
  );

endmodule

// File: rtl/idxmix_prng.sv
module idxmix_prng
  import idxmix_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seedLoad,
  input  logic              startReq,
  output logic [WORD_W-1:0] resWord,
  output logic              resValid
);

  strobe_t strb;

  idxmix_ctrl #(.TICKS(STAGE_TICKS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .startReq (startReq),
    .strb     (strb)
  );

  idxmix_dpath #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .strb     (strb),
    .resWord  (resWord),
    .resValid (resValid)
  );

endmodule

// File: rtl/idxmix_prng_chk.sv
module idxmix_prng_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              seedLoad,
  input logic [WORD_W-1:0] resWord,
  input logic              resValid,
  input logic              addLo,
  input logic              addHi,
  input logic              memWr
);

  logic [3:0] gapCnt;
  logic       seenValid;

  always_ff @(posedge clk) begin
    if (rst || seedLoad) begin
      gapCnt    <= '0;
      seenValid <= 1'b0;
    end else if (resValid) begin
      gapCnt    <= '0;
      seenValid <= 1'b1;
    end else if (gapCnt != 4'd15) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst || seedLoad) |-> (!resValid && resWord == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst || seedLoad)
    resValid |=> !resValid);

  p_cadence_r6: assert property (@(posedge clk) disable iff (rst || seedLoad)
    (resValid && seenValid) |-> (gapCnt >= 4'd9));

  p_lo_then_hi_r10: assert property (@(posedge clk) disable iff (rst || seedLoad)
    addLo |=> addHi);

  p_adder_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(addLo && addHi));

  p_write_after_sum_r3: assert property (@(posedge clk) disable iff (rst || seedLoad)
    memWr |-> $past(addHi));

endmodule

bind idxmix_prng idxmix_prng_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .seedLoad (seedLoad),
  .resWord  (resWord),
  .resValid (resValid),
  .addLo    (strb.addLo),
  .addHi    (strb.addHi),
  .memWr    (strb.memWr)
);

// File: tb/idxmix_prng_bench.sv
`timescale 1ns/1ps
module idxmix_prng_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        seedLoad = 1'b0;
  logic        startReq = 1'b0;
  logic [31:0] resWord;
  logic        resValid;

  int     vectors = 0;
  int     miscompares = 0;
  longint cycle = 0;

  logic [31:0] mdl [64];
  logic [31:0] mA, mB;
  int          mI;
  logic [31:0] expQ [$];
  logic [31:0] firstWord;
  logic        prevValid = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycle++;

  idxmix_prng u_idxmix_prng (
    .clk      (clk),
    .rst      (rst),
    .seedLoad (seedLoad),
    .startReq (startReq),
    .resWord  (resWord),
    .resValid (resValid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Software model of R1..R4
  task automatic modelSeed();
    for (int k = 0; k < 64; k++) mdl[k] = 32'hFFFF_FFFF;
    mA = 32'hFFFF_FFFF;
    mB = 32'hFFFF_FFFF;
    mI = 0;
  endtask

  function automatic logic [31:0] modelStep();
    logic [31:0] x, y, s;
    x = mdl[mI];
    case (mI % 4)
      0: s = mA << 13;
      1: s = mA >> 6;
      2: s = mA << 2;
      default: s = mA >> 16;
    endcase
    mA = (mA ^ s) + mdl[(mI + 32) % 64];
    y = mdl[x[7:2]] + mA + mB;
    mdl[mI] = y;
    mB = mdl[y[13:8]] + x;
    mI = (mI + 1) % 64;
    return mB;
  endfunction

  task automatic pushExpected(input int n);
    for (int k = 0; k < n; k++) expQ.push_back(modelStep());
  endtask

  // Monitor: pops one expected word per result pulse
  always @(negedge clk) begin : monitor
    logic [31:0] e;
    if (!rst && resValid) begin
      check(!prevValid, "R5 valid longer than one cycle", 32'(prevValid), 32'd0);
      if (expQ.size() == 0) begin
        check(1'b0, "R7 R9 result without request", resWord, 32'd0);
      end else begin
        e = expQ.pop_front();
        check(resWord == e, "R2,R3,R4,R10 result word", resWord, e);
      end
    end
    prevValid = resValid && !rst;
  end

  initial begin : watchdog
    wait (cycle > 60000);
    check(1'b0, "watchdog R6 R7", 32'(cycle), 32'd60000);
    finishRun();
  end

  task automatic drain();
    repeat (16) @(negedge clk);
    check(expQ.size() == 0, "R7 every request answered", 32'(expQ.size()), 32'd0);
  endtask

  // Continuous request: n results, gaps of exactly 10 cycles
  task automatic runStream(input int n);
    int     got = 0;
    longint lastCyc = -1;
    pushExpected(n);
    @(negedge clk) startReq = 1'b1;
    while (got < n) begin
      @(negedge clk);
      if (resValid) begin
        got++;
        if (lastCyc >= 0)
          check(cycle - lastCyc == 10, "R6 result spacing", 32'(cycle - lastCyc), 32'd10);
        lastCyc = cycle;
        if (got == n - 1) startReq = 1'b0;
      end
    end
    startReq = 1'b0;
    drain();
  endtask

  // One-cycle request after a delay; latency 10..14 edges
  task automatic pulseOnce(input int delay);
    int n = 0;
    repeat (delay) @(negedge clk);
    pushExpected(1);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    while (!resValid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(n >= 10 && n <= 14, "R7 start latency", 32'(n), 32'd12);
    drain();
  endtask

  initial begin : stimulus
    int     idleHits;
    longint c1;
    int     n;
    modelSeed();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(resValid == 1'b0, "R1 valid after reset", 32'(resValid), 32'd0);
    check(resWord == 32'd0, "R1 word after reset", resWord, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(resValid == 1'b0 && resWord == 32'd0, "R1 first cycle out of reset", resWord, 32'd0);

    firstWord = 32'd0;
    begin
      logic [31:0] sv [64];
      logic [31:0] a0, b0;
      sv = mdl; a0 = mA; b0 = mB;
      firstWord = modelStep();
      mdl = sv; mA = a0; mB = b0; mI = 0;
    end

    // Long stream past the 64-entry wrap (R4) at full rate (R6)
    runStream(70);

    // R9: idle, no pulses, state untouched (checked by next result)
    idleHits = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (resValid) idleHits++;
    end
    check(idleHits == 0, "R9 no result while idle", 32'(idleHits), 32'd0);

    // R7: single pulses at varied phases of the free-running stage counter
    for (int d = 0; d < 5; d++) pulseOnce(d);

    // R7: request while busy is held and starts right after
    pushExpected(2);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (6) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    n = 0;
    while (!resValid && n < 40) begin @(negedge clk); n++; end
    c1 = cycle;
    @(negedge clk);
    n = 0;
    while (!resValid && n < 40) begin @(negedge clk); n++; end
    check(cycle - c1 == 10, "R7 busy request gap", 32'(cycle - c1), 32'd10);
    drain();

    // R8: seed reload mid-run and while idle
    pushExpected(1);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (4) @(negedge clk);
    seedLoad = 1'b1;
    @(negedge clk) seedLoad = 1'b0;
    expQ.delete();
    check(resValid == 1'b0 && resWord == 32'd0, "R8 outputs cleared by seed load", resWord, 32'd0);
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R8 aborted work produces nothing", 32'(expQ.size()), 32'd0);
    modelSeed();
    pushExpected(1);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    n = 0;
    while (!resValid && n < 40) begin @(negedge clk); n++; end
    check(resWord == firstWord, "R8 sequence restarts from seed", resWord, firstWord);
    drain();
    runStream(6);

    finishRun();
  end

endmodule